// File: doc/BRIEF.md
# Microsecond Timebase with Fractional Prescaler

This block turns a reference clock of 12, 13, 19.2 or 26 MHz into a steady one-microsecond tick and keeps a free-running up-counter of those ticks. The prescaler is not a plain integer divider. A 16-bit ratio word gives a dividend and a divisor. Every reference cycle adds the dividend to an accumulator, and a tick is issued each time the accumulator reaches the divisor. Rates that do not divide evenly, such as 19.2 MHz, therefore still average exactly 1 MHz.

Software reaches the block through a small synchronous register port. The port gives read access to the running count. It gives read and write access to the ratio word, so the word can be saved and restored across power states. It also holds a one-bit hold control that stops both the accumulator and the counter. The tick is also driven out as a one-cycle pulse for local consumers.

Top module: `usec_timebase`

## Requirements
- R1: After reset the counter reads 0, `tick_o` is low, the ratio word (offset 0x14) reads 0x0000000B and the hold bit (offset 0x4C, bit 0) reads 0.
- R2: The ratio word at offset 0x14 is read/write in bits [15:0]. Bits [31:16] read back as 0 whatever was written.
- R3: With dividend D = ratio[15:8]+1 and divisor V = ratio[7:0]+1 and D < V, the counter rises by exactly floor(m*D/V) over m running cycles that start from a cleared accumulator. The accumulator value always stays below V.
- R4: When D >= V, every running cycle except a ratio write produces a tick. There is never more than one tick per reference cycle.
- R5: `tick_o` is a one-cycle pulse. The counter (`usec_o` and offset 0x10) steps by exactly 1 on each edge that raises `tick_o` and holds on every other edge.
- R6: While the hold bit is 1, neither the accumulator nor the counter moves and no tick is issued. On release, counting resumes from the held accumulator phase.
- R7: The counter wraps from its all-ones value to 0.
- R8: A write to the ratio word clears the accumulator and issues no tick in that cycle. The next tick follows after a full new period.
- R9: Writes to the counter offset and to unmapped offsets change nothing. Unmapped offsets read as 0.
- R10: `reg_rdata` is registered. It shows the addressed value one cycle after `reg_ren` and holds while no read is strobed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wen | input | 1 | Register write strobe |
| reg_ren | input | 1 | Register read strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| tick_o | output | 1 | One-cycle microsecond tick |
| usec_o | output | COUNT_W (32) | Microsecond count |

## Verification
A ratio or hold write takes effect at the edge that samples it. That edge still advances under the old hold value, so the first running edge after a release is the one after the write. The counter and `tick_o` change on the same edge, so a tick seen at a falling edge belongs to the count already shown there. Read data becomes visible one edge after the strobe and shows the value from before that edge. The scoreboard queues each expected read value when it issues the strobe and compares it at the following falling edge. The hold-release, clear and fast-ratio checks count running edges from the write edge and sample `usec_o` at falling edges only.

// File: rtl/usec_base_pkg.sv
package usec_base_pkg;

    parameter int unsigned REG_DATA_W = 32;
    parameter int unsigned REG_ADDR_W = 8;
    parameter int unsigned RATIO_W    = 8;

    parameter logic [REG_ADDR_W-1:0] OFS_COUNT  = 8'h10;
    parameter logic [REG_ADDR_W-1:0] OFS_RATIO  = 8'h14;
    parameter logic [REG_ADDR_W-1:0] OFS_HOLD   = 8'h4c;

    parameter logic [2*RATIO_W-1:0] RATIO_RESET = 16'h000b;

endpackage

// File: rtl/usec_frac_prescaler.sv
module usec_frac_prescaler
    import usec_base_pkg::*;
#(
    parameter int unsigned RW = RATIO_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [2*RW-1:0] ratio,
    input  logic            clr,
    input  logic            hold,
    output logic            tick_next,
    output logic            tick,
    output logic [RW:0]     acc
);

    localparam int unsigned AW = RW + 1;
    localparam int unsigned SW = AW + 1;

    typedef struct packed {
        logic [AW-1:0] acc;
        logic          tick;
    } presc_t;

    presc_t st_q, st_d;

    logic [AW-1:0] dividend;
    logic [AW-1:0] divisor;
    logic [SW-1:0] sum;
    logic [SW-1:0] rem;

    always_comb begin
        dividend = {1'b0, ratio[2*RW-1:RW]} + AW'(1);
        divisor  = {1'b0, ratio[RW-1:0]} + AW'(1);
        sum      = {1'b0, st_q.acc} + {1'b0, dividend};
        rem      = sum - {1'b0, divisor};
        st_d     = st_q;
        st_d.tick = 1'b0;
        if (clr) begin
            st_d.acc = '0;
        end else if (!hold) begin
            if (sum >= {1'b0, divisor}) begin
                st_d.tick = 1'b1;
                // keep the phase below the divisor: one tick per cycle at most
                if (rem >= {1'b0, divisor}) begin
                    st_d.acc = divisor - AW'(1);
                end else begin
                    st_d.acc = rem[AW-1:0];
                end
            end else begin
                st_d.acc = sum[AW-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tick_next = st_d.tick;
    assign tick      = st_q.tick;
    assign acc       = st_q.acc;

endmodule

// File: rtl/usec_up_counter.sv
module usec_up_counter #(
    parameter int unsigned COUNT_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               adv,
    output logic [COUNT_W-1:0] count
);

    typedef struct packed {
        logic [COUNT_W-1:0] cnt;
    } cnt_t;

    cnt_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (adv) begin
            st_d.cnt = st_q.cnt + COUNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count = st_q.cnt;

endmodule

// File: rtl/usec_regfile.sv
module usec_regfile
    import usec_base_pkg::*;
#(
    parameter int unsigned COUNT_W = 32,
    parameter int unsigned RW      = RATIO_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wen,
    input  logic                  ren,
    input  logic [REG_ADDR_W-1:0] addr,
    input  logic [REG_DATA_W-1:0] wdata,
    input  logic [COUNT_W-1:0]    count,
    output logic [2*RW-1:0]       ratio,
    output logic                  hold,
    output logic                  ratio_we,
    output logic [REG_DATA_W-1:0] rdata
);

    localparam int unsigned CFG_W = 2 * RW;

    typedef struct packed {
        logic [CFG_W-1:0]      ratio;
        logic                  hold;
        logic [REG_DATA_W-1:0] rdata;
    } regs_t;

    regs_t st_q, st_d;

    logic [REG_DATA_W-1:0] count_ext;
    logic [REG_DATA_W-1:0] ratio_ext;
    logic                  unused_wdata_hi;

    generate
        if (COUNT_W < REG_DATA_W) begin : g_cnt_pad
            assign count_ext = {{(REG_DATA_W-COUNT_W){1'b0}}, count};
        end else begin : g_cnt_full
            assign count_ext = count[REG_DATA_W-1:0];
        end
        if (CFG_W < REG_DATA_W) begin : g_cfg_pad
            assign ratio_ext       = {{(REG_DATA_W-CFG_W){1'b0}}, st_q.ratio};
            assign unused_wdata_hi = ^wdata[REG_DATA_W-1:CFG_W];
        end else begin : g_cfg_full
            assign ratio_ext       = st_q.ratio[REG_DATA_W-1:0];
            assign unused_wdata_hi = 1'b0;
        end
    endgenerate

    assign ratio_we = wen && (addr == OFS_RATIO);

    always_comb begin
        st_d = st_q;
        if (ratio_we) begin
            st_d.ratio = wdata[CFG_W-1:0];
        end
        if (wen && (addr == OFS_HOLD)) begin
            st_d.hold = wdata[0];
        end
        if (ren) begin
            case (addr)
                OFS_COUNT: st_d.rdata = count_ext;
                OFS_RATIO: st_d.rdata = ratio_ext;
                OFS_HOLD:  st_d.rdata = {{(REG_DATA_W-1){1'b0}}, st_q.hold};
                default:   st_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ratio <= CFG_W'(RATIO_RESET);
            st_q.hold  <= 1'b0;
            st_q.rdata <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ratio = st_q.ratio;
    assign hold  = st_q.hold;
    assign rdata = st_q.rdata;

endmodule

// File: rtl/usec_timebase.sv
module usec_timebase
    import usec_base_pkg::*;
#(
    parameter int unsigned COUNT_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_wen,
    input  logic                  reg_ren,
    input  logic [REG_ADDR_W-1:0] reg_addr,
    input  logic [REG_DATA_W-1:0] reg_wdata,
    output logic [REG_DATA_W-1:0] reg_rdata,
    output logic                  tick_o,
    output logic [COUNT_W-1:0]    usec_o
);

    logic [2*RATIO_W-1:0] ratio_w;
    logic                 hold_w;
    logic                 ratio_we_w;
    logic                 tick_next_w;
    logic [RATIO_W:0]     acc_w;

    usec_regfile #(
        .COUNT_W (COUNT_W),
        .RW      (RATIO_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wen      (reg_wen),
        .ren      (reg_ren),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .count    (usec_o),
        .ratio    (ratio_w),
        .hold     (hold_w),
        .ratio_we (ratio_we_w),
        .rdata    (reg_rdata)
    );

    usec_frac_prescaler #(
        .RW (RATIO_W)
    ) u_presc (
        .clk       (clk),
        .rst_n     (rst_n),
        .ratio     (ratio_w),
        .clr       (ratio_we_w),
        .hold      (hold_w),
        .tick_next (tick_next_w),
        .tick      (tick_o),
        .acc       (acc_w)
    );

    usec_up_counter #(
        .COUNT_W (COUNT_W)
    ) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (tick_next_w),
        .count (usec_o)
    );

endmodule

// File: rtl/usec_timebase_chk.sv
module usec_timebase_chk
    import usec_base_pkg::*;
#(
    parameter int unsigned COUNT_W = 32
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  tick_o,
    input logic [COUNT_W-1:0]    usec_o,
    input logic                  hold,
    input logic [2*RATIO_W-1:0]  ratio,
    input logic                  ratio_we,
    input logic                  reg_ren,
    input logic [REG_DATA_W-1:0] reg_rdata,
    input logic [RATIO_W:0]      acc
);

    // R5
    tick_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |-> (usec_o - $past(usec_o)) == COUNT_W'(1))
        else $error("count did not step with tick");

    // R5
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_o |-> $stable(usec_o))
        else $error("count moved without tick");

    // R6
    hold_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> !tick_o)
        else $error("tick while held");

    // R4
    fast_ratio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && !ratio_we && (ratio[2*RATIO_W-1:RATIO_W] >= ratio[RATIO_W-1:0])) |=> tick_o)
        else $error("missing tick at ratio >= 1");

    // R3
    acc_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc <= {1'b0, ratio[RATIO_W-1:0]})
        else $error("accumulator reached divisor");

    // R8
    ratio_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ratio_we |=> (acc == '0) && !tick_o)
        else $error("ratio write did not clear phase");

    // R10
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_ren |=> $stable(reg_rdata))
        else $error("read data changed without read");

endmodule

bind usec_timebase usec_timebase_chk #(.COUNT_W(COUNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_o    (tick_o),
    .usec_o    (usec_o),
    .hold      (hold_w),
    .ratio     (ratio_w),
    .ratio_we  (ratio_we_w),
    .reg_ren   (reg_ren),
    .reg_rdata (reg_rdata),
    .acc       (acc_w)
);

// File: tb/usec_timebase_bench.sv
`timescale 1ns/1ps
module usec_timebase_bench;

    localparam logic [7:0] A_CNT  = 8'h10;
    localparam logic [7:0] A_RAT  = 8'h14;
    localparam logic [7:0] A_HOLD = 8'h4c;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wen = 1'b0;
    logic        ren = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        tick;
    logic [31:0] usec;

    logic [31:0] n_rdata;
    logic        n_tick;
    logic [9:0]  n_usec;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    string       exp_tag_q[$];
    logic [31:0] exp_val_q[$];
    logic        rd_seen = 1'b0;
    int          tick_seen = 0;
    logic [9:0]  n_prev = '0;
    bit          wrapped = 0;

    always #4 clk = ~clk;

    usec_timebase u_usec_timebase (
        .clk(clk), .rst_n(rst_n), .reg_wen(wen), .reg_ren(ren), .reg_addr(addr),
        .reg_wdata(wdata), .reg_rdata(rdata), .tick_o(tick), .usec_o(usec)
    );

    usec_timebase #(.COUNT_W(10)) u_narrow (
        .clk(clk), .rst_n(rst_n), .reg_wen(1'b0), .reg_ren(1'b0), .reg_addr(8'h00),
        .reg_wdata(32'h0), .reg_rdata(n_rdata), .tick_o(n_tick), .usec_o(n_usec)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // monitor: compares read data one edge after the strobe
    always @(posedge clk) rd_seen <= ren && rst_n;

    always @(negedge clk) begin
        if (rst_n && tick) tick_seen++;
        if (rd_seen) begin
            if (exp_val_q.size() == 0) begin
                check("R10 unexpected read", rdata, 32'hx);
            end else begin
                check(exp_tag_q.pop_front(), rdata, exp_val_q.pop_front());
            end
        end
        if (rst_n) begin
            if (n_prev == 10'h3ff && n_usec == 10'h000) wrapped = 1;
            n_prev = n_usec;
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wen = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wen = 1'b0;
    endtask

    task automatic rd_expect(input logic [7:0] a, input logic [31:0] e, input string tag);
        @(negedge clk);
        ren = 1'b1; addr = a;
        exp_tag_q.push_back(tag);
        exp_val_q.push_back(e);
        @(negedge clk);
        ren = 1'b0;
    endtask

    function automatic logic [31:0] ticks_for(input int unsigned m, input logic [15:0] c);
        int unsigned d = int'(c[15:8]) + 1;
        int unsigned v = int'(c[7:0]) + 1;
        if (d >= v) return m;
        return (m * d) / v;
    endfunction

    initial begin
        #(200000 * 8);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [15:0] cfgs [4];
        int          ks   [4];
        logic [31:0] base;
        int          t0;
        cfgs = '{16'h000b, 16'h000c, 16'h045f, 16'h0019};
        ks   = '{239, 259, 959, 99};

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1 count", usec, 32'h0);
        check("R1 tick", {31'h0, tick}, 32'h0);
        rd_expect(A_RAT, 32'h0000000b, "R1 ratio");
        rd_expect(A_HOLD, 32'h0, "R1 hold");

        // hold
        wr(A_HOLD, 32'h1);
        rd_expect(A_HOLD, 32'h1, "R6 hold readback");
        base = usec;
        repeat (20) @(negedge clk);
        check("R6 count held", usec, base);

        // R3 rates for the four reference clocks
        foreach (cfgs[i]) begin
            wr(A_RAT, {16'h0, cfgs[i]});
            rd_expect(A_RAT, {16'h0, cfgs[i]}, "R2 ratio readback");
            base = usec;
            t0 = tick_seen;
            wr(A_HOLD, 32'h0);
            repeat (ks[i]) @(negedge clk);
            rd_expect(A_CNT, base + ticks_for(ks[i] + 1, cfgs[i]), "R3 rate");
            wr(A_HOLD, 32'h1);
            repeat (2) @(negedge clk);
            check("R5 tick pulses", 32'(tick_seen - t0), usec - base);
        end

        // R6 resume from held phase (12 MHz, phase 6)
        wr(A_RAT, 32'h000b);
        wr(A_HOLD, 32'h0);
        repeat (4) @(negedge clk);
        wr(A_HOLD, 32'h1);
        repeat (30) @(negedge clk);
        base = usec;
        wr(A_HOLD, 32'h0);
        repeat (5) @(negedge clk);
        check("R6 resume before", usec, base);
        @(negedge clk);
        check("R6 resume tick", usec, base + 1);

        // R8 ratio write clears phase mid-period
        repeat (3) @(negedge clk);
        wr(A_RAT, 32'h000b);
        base = usec;
        repeat (11) @(negedge clk);
        check("R8 no early tick", usec, base);
        @(negedge clk);
        check("R8 full period", usec, base + 1);

        // R4 ratios with dividend >= divisor
        wr(A_RAT, 32'h0100);
        base = usec;
        for (int i = 1; i <= 6; i++) begin
            @(negedge clk);
            check("R4 every cycle 2/1", usec, base + i);
        end
        check("R4 tick high", {31'h0, tick}, 32'h1);
        wr(A_RAT, 32'h0505);
        base = usec;
        for (int i = 1; i <= 6; i++) begin
            @(negedge clk);
            check("R4 every cycle 6/6", usec, base + i);
        end

        // R9 ignored writes, R2 upper bits
        wr(A_HOLD, 32'h1);
        repeat (2) @(negedge clk);
        base = usec;
        wr(A_CNT, 32'h12345678);
        rd_expect(A_CNT, base, "R9 count write ignored");
        check("R9 count port", usec, base);
        wr(8'h20, 32'hffffffff);
        rd_expect(8'h20, 32'h0, "R9 unmapped reads 0");
        rd_expect(A_RAT, 32'h00000505, "R9 ratio untouched");
        wr(A_RAT, 32'habcd045f);
        rd_expect(A_RAT, 32'h0000045f, "R2 upper bits zero");

        // R10 read data holds
        repeat (5) @(negedge clk);
        check("R10 rdata held", rdata, 32'h0000045f);

        // R7 wrap on the narrow instance
        for (int i = 0; i < 14000 && !wrapped; i++) @(negedge clk);
        check("R7 wrap to zero", {31'h0, wrapped}, 32'h1);

        check("R10 scoreboard drained", 32'(exp_val_q.size()), 32'h0);
        finish_run();
    end

endmodule